// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 36-bit virtual page number into a 40-bit physical page number. It reads a radix tree of page tables that is four levels deep, with one 64-bit word fetched from memory per level. The first table is found from a root page-number input. At each level nine bits of the virtual page number pick one of 512 eight-byte entries in the current table. The entry is checked, and either its address field gives the next table or the walk stops with a fault. After the fourth entry the walker writes that entry back to memory with the accessed flag set, and with the dirty flag also set for a write request. It then reports the page number and the control flags merged over all levels.

Requests arrive on a valid/ready pair and only one walk runs at a time. Memory is reached through one request channel, shared by reads and the write-back, plus a read-response channel. Every result is reported as a one-cycle completion pulse that carries either a translation or a fault cause.

Entry layout used throughout: bit 0 valid, bit 1 writable, bit 2 user-accessible, bit 5 accessed, bit 6 dirty, bits 51..12 next-table or physical page number. The other bits are carried without interpretation.

Top module: `ptw_engine`

## Requirements
- R1: After reset, req_ready_o is 1 and both mem_req_valid_o and done_valid_o are 0.
- R2: A request is taken when req_valid_i and req_ready_o are both 1 at a clock edge. From the next cycle until the completion pulse, req_ready_o stays 0.
- R3: Each read asks for byte address {table_ppn, index, 3'b000}. For the four levels the index is, in order, vpn[35:27], vpn[26:18], vpn[17:9] and vpn[8:0], and the first table_ppn is root_ppn_i.
- R4: For the next level, table_ppn is taken from bits 51..12 of the entry just read.
- R5: An entry with bit 0 clear ends the walk with fault 1 and cause 1. No further read and no write-back is issued.
- R6: If bit 0 is set but a user request (req_user_i=1) meets an entry with bit 2 clear, the walk ends with fault and cause 2 at that level.
- R7: A write request meeting an entry with bit 1 clear faults with cause 3. The per-level priority is cause 1, then cause 2, then cause 3.
- R8: A successful walk issues exactly one memory write, to the last-level entry address, before completing. Its data is the entry with bit 5 set and with bit 6 also set for a write request; every other bit is unchanged.
- R9: On success, done_ppn_o is bits 51..12 of the last entry and done_fault_o and done_cause_o are 0. done_flags_o is the written-back value's bits 11..0, except that bits 1 and 2 are the AND of those bits over all four entries.
- R10: A memory request, reads and the write alike, keeps valid, address, write flag and data steady until mem_req_ready_i is seen. A read waits for mem_rsp_valid_i. The write needs no response.
- R11: done_valid_o is high for exactly one cycle per accepted request, and req_ready_o is 1 in the following cycle. On a fault, done_ppn_o and done_flags_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_ppn_i | input | 40 | Page number of the top-level table |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Walker idle, request can be taken |
| req_vpn_i | input | 36 | Virtual page number to translate |
| req_write_i | input | 1 | Request is a store |
| req_user_i | input | 1 | Request comes from user mode |
| mem_req_valid_o | output | 1 | Memory request present |
| mem_req_ready_i | input | 1 | Memory takes the request |
| mem_req_addr_o | output | 52 | Byte address of the entry |
| mem_req_we_o | output | 1 | 1 for the write-back, 0 for a read |
| mem_req_wdata_o | output | 64 | Write-back data |
| mem_rsp_valid_i | input | 1 | Read data present |
| mem_rsp_data_i | input | 64 | Read data |
| done_valid_o | output | 1 | One-cycle completion pulse |
| done_fault_o | output | 1 | Walk ended in a fault |
| done_cause_o | output | 2 | 0 none, 1 invalid entry, 2 user denied, 3 write denied |
| done_ppn_o | output | 40 | Translated physical page number |
| done_flags_o | output | 12 | Merged control flags |

## Verification
The checks assume memory sends exactly one read response per accepted read, and only while that read is outstanding. They also assume the write-back gets no response. The bench memory model follows this. It records each handshake, then returns data after a random delay of zero to two cycles, and it toggles the ready input at random. Requests are raised only while the walker reports idle, so no request is presented while a walk is in progress.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    // control flag positions inside a table entry
    localparam int FLG_VALID = 0;
    localparam int FLG_WRITE = 1;
    localparam int FLG_USER  = 2;
    localparam int FLG_ACC   = 5;
    localparam int FLG_DIRTY = 6;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_RD_REQ,
        WS_RD_WAIT,
        WS_WB_REQ,
        WS_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        FC_NONE    = 2'd0,
        FC_INVALID = 2'd1,
        FC_USER    = 2'd2,
        FC_WRITE   = 2'd3
    } fault_cause_e;

endpackage

// File: rtl/ptw_index.sv
module ptw_index #(
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int PPN_W  = 40,
    parameter int OFS_W  = 3,
    localparam int VPN_W = LEVELS * IDX_W,
    localparam int LVL_W = $clog2(LEVELS),
    localparam int PA_W  = PPN_W + IDX_W + OFS_W
) (
    input  logic [VPN_W-1:0] vpn_i,
    input  logic [LVL_W-1:0] lvl_i,
    input  logic [PPN_W-1:0] table_i,
    output logic [PA_W-1:0]  addr_o
);

    logic [IDX_W-1:0] slice_w [LEVELS];

    // level 0 takes the most significant slice
    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
        assign slice_w[g] = vpn_i[(LEVELS-1-g)*IDX_W +: IDX_W];
    end

    assign addr_o = {table_i, slice_w[lvl_i], {OFS_W{1'b0}}};

endmodule

// File: rtl/ptw_check.sv
module ptw_check
    import ptw_pkg::*;
(
    input  logic       ent_valid_i,
    input  logic       ent_write_i,
    input  logic       ent_user_i,
    input  logic       is_write_i,
    input  logic       is_user_i,
    output logic [1:0] cause_o
);

    always_comb begin
        if (!ent_valid_i) begin
            cause_o = FC_INVALID;
        end else if (is_user_i && !ent_user_i) begin
            cause_o = FC_USER;
        end else if (is_write_i && !ent_write_i) begin
            cause_o = FC_WRITE;
        end else begin
            cause_o = FC_NONE;
        end
    end

endmodule

// File: rtl/ptw_leaf.sv
module ptw_leaf
    import ptw_pkg::*;
#(
    parameter int ENT_W = 64,
    parameter int PG_W  = 12,
    parameter int PPN_W = 40
) (
    input  logic [ENT_W-1:0] leaf_i,
    input  logic             is_write_i,
    input  logic             perm_w_i,
    input  logic             perm_u_i,
    output logic [ENT_W-1:0] wb_data_o,
    output logic [PG_W-1:0]  flags_o,
    output logic [PPN_W-1:0] ppn_o
);

    always_comb begin
        wb_data_o            = leaf_i;
        wb_data_o[FLG_ACC]   = 1'b1;
        wb_data_o[FLG_DIRTY] = leaf_i[FLG_DIRTY] | is_write_i;
        flags_o              = wb_data_o[PG_W-1:0];
        flags_o[FLG_WRITE]   = perm_w_i;
        flags_o[FLG_USER]    = perm_u_i;
        ppn_o                = leaf_i[PG_W +: PPN_W];
    end

endmodule

// File: rtl/ptw_engine.sv
module ptw_engine
    import ptw_pkg::*;
#(
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int PG_W   = 12,
    parameter int PPN_W  = 40,
    parameter int ENT_W  = 64,
    localparam int VPN_W = LEVELS * IDX_W,
    localparam int OFS_W = PG_W - IDX_W,
    localparam int PA_W  = PPN_W + PG_W,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PPN_W-1:0] root_ppn_i,
    input  logic             req_valid_i,
    output logic             req_ready_o,
    input  logic [VPN_W-1:0] req_vpn_i,
    input  logic             req_write_i,
    input  logic             req_user_i,
    output logic             mem_req_valid_o,
    input  logic             mem_req_ready_i,
    output logic [PA_W-1:0]  mem_req_addr_o,
    output logic             mem_req_we_o,
    output logic [ENT_W-1:0] mem_req_wdata_o,
    input  logic             mem_rsp_valid_i,
    input  logic [ENT_W-1:0] mem_rsp_data_i,
    output logic             done_valid_o,
    output logic             done_fault_o,
    output logic [1:0]       done_cause_o,
    output logic [PPN_W-1:0] done_ppn_o,
    output logic [PG_W-1:0]  done_flags_o
);

    typedef struct packed {
        walk_state_e      st;
        logic [LVL_W-1:0] lvl;
        logic [PPN_W-1:0] tbl;
        logic [VPN_W-1:0] vpn;
        logic             wr;
        logic             usr;
        logic             perm_w;
        logic             perm_u;
        logic [ENT_W-1:0] leaf;
        logic             fault;
        logic [1:0]       cause;
    } walk_s;

    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    walk_s r_d, r_q;

    logic [1:0]       chk_cause_w;
    logic [ENT_W-1:0] wb_data_w;
    logic [PG_W-1:0]  leaf_flags_w;
    logic [PPN_W-1:0] leaf_ppn_w;

    ptw_index #(
        .LEVELS (LEVELS),
        .IDX_W  (IDX_W),
        .PPN_W  (PPN_W),
        .OFS_W  (OFS_W)
    ) u_index (
        .vpn_i   (r_q.vpn),
        .lvl_i   (r_q.lvl),
        .table_i (r_q.tbl),
        .addr_o  (mem_req_addr_o)
    );

    ptw_check u_check (
        .ent_valid_i (mem_rsp_data_i[FLG_VALID]),
        .ent_write_i (mem_rsp_data_i[FLG_WRITE]),
        .ent_user_i  (mem_rsp_data_i[FLG_USER]),
        .is_write_i  (r_q.wr),
        .is_user_i   (r_q.usr),
        .cause_o     (chk_cause_w)
    );

    ptw_leaf #(
        .ENT_W (ENT_W),
        .PG_W  (PG_W),
        .PPN_W (PPN_W)
    ) u_leaf (
        .leaf_i     (r_q.leaf),
        .is_write_i (r_q.wr),
        .perm_w_i   (r_q.perm_w),
        .perm_u_i   (r_q.perm_u),
        .wb_data_o  (wb_data_w),
        .flags_o    (leaf_flags_w),
        .ppn_o      (leaf_ppn_w)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            WS_IDLE: begin
                if (req_valid_i) begin
                    r_d.st     = WS_RD_REQ;
                    r_d.lvl    = '0;
                    r_d.tbl    = root_ppn_i;
                    r_d.vpn    = req_vpn_i;
                    r_d.wr     = req_write_i;
                    r_d.usr    = req_user_i;
                    r_d.perm_w = 1'b1;
                    r_d.perm_u = 1'b1;
                    r_d.leaf   = '0;
                    r_d.fault  = 1'b0;
                    r_d.cause  = FC_NONE;
                end
            end
            WS_RD_REQ: begin
                if (mem_req_ready_i) r_d.st = WS_RD_WAIT;
            end
            WS_RD_WAIT: begin
                if (mem_rsp_valid_i) begin
                    if (chk_cause_w != FC_NONE) begin
                        r_d.fault = 1'b1;
                        r_d.cause = chk_cause_w;
                        r_d.st    = WS_DONE;
                    end else begin
                        r_d.perm_w = r_q.perm_w & mem_rsp_data_i[FLG_WRITE];
                        r_d.perm_u = r_q.perm_u & mem_rsp_data_i[FLG_USER];
                        if (r_q.lvl == LAST_LVL) begin
                            r_d.leaf = mem_rsp_data_i;
                            r_d.st   = WS_WB_REQ;
                        end else begin
                            r_d.tbl = mem_rsp_data_i[PG_W +: PPN_W];
                            r_d.lvl = r_q.lvl + 1'b1;
                            r_d.st  = WS_RD_REQ;
                        end
                    end
                end
            end
            WS_WB_REQ: begin
                if (mem_req_ready_i) r_d.st = WS_DONE;
            end
            WS_DONE: begin
                r_d.st = WS_IDLE;
            end
            default: r_d.st = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready_o     = (r_q.st == WS_IDLE);
    assign mem_req_valid_o = (r_q.st == WS_RD_REQ) || (r_q.st == WS_WB_REQ);
    assign mem_req_we_o    = (r_q.st == WS_WB_REQ);
    assign mem_req_wdata_o = mem_req_we_o ? wb_data_w : '0;
    assign done_valid_o    = (r_q.st == WS_DONE);
    assign done_fault_o    = r_q.fault;
    assign done_cause_o    = r_q.cause;
    assign done_ppn_o      = r_q.fault ? '0 : leaf_ppn_w;
    assign done_flags_o    = r_q.fault ? '0 : leaf_flags_w;

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o && !mem_req_ready_i |=>
            mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_we_o)
            && $stable(mem_req_wdata_o));

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && req_ready_o |=> !req_ready_o);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid_o |=> !done_valid_o && req_ready_o);

    // R8
    wb_sets_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o && mem_req_we_o |-> mem_req_wdata_o[FLG_ACC]);

    // R5
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid_o |-> (done_fault_o == (done_cause_o != 2'd0)));

    // R9
    ok_has_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid_o && !done_fault_o |-> done_flags_o[FLG_ACC] && done_flags_o[FLG_VALID]);

endmodule

// File: tb/sim_ptw_engine.sv
module sim_ptw_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] root_ppn_i = 40'h0_0012_3450;
    logic        req_valid_i = 1'b0;
    logic        req_ready_o;
    logic [35:0] req_vpn_i = '0;
    logic        req_write_i = 1'b0;
    logic        req_user_i = 1'b0;
    logic        mem_req_valid_o;
    logic        mem_req_ready_i = 1'b0;
    logic [51:0] mem_req_addr_o;
    logic        mem_req_we_o;
    logic [63:0] mem_req_wdata_o;
    logic        mem_rsp_valid_i = 1'b0;
    logic [63:0] mem_rsp_data_i = '0;
    logic        done_valid_o;
    logic        done_fault_o;
    logic [1:0]  done_cause_o;
    logic [39:0] done_ppn_o;
    logic [11:0] done_flags_o;

    always #2 clk = ~clk;   // 250 MHz

    ptw_engine u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .root_ppn_i      (root_ppn_i),
        .req_valid_i     (req_valid_i),
        .req_ready_o     (req_ready_o),
        .req_vpn_i       (req_vpn_i),
        .req_write_i     (req_write_i),
        .req_user_i      (req_user_i),
        .mem_req_valid_o (mem_req_valid_o),
        .mem_req_ready_i (mem_req_ready_i),
        .mem_req_addr_o  (mem_req_addr_o),
        .mem_req_we_o    (mem_req_we_o),
        .mem_req_wdata_o (mem_req_wdata_o),
        .mem_rsp_valid_i (mem_rsp_valid_i),
        .mem_rsp_data_i  (mem_rsp_data_i),
        .done_valid_o    (done_valid_o),
        .done_fault_o    (done_fault_o),
        .done_cause_o    (done_cause_o),
        .done_ppn_o      (done_ppn_o),
        .done_flags_o    (done_flags_o)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [63:0] mem [logic [51:0]];
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic [51:0] rd_addr_log [4];
    logic [51:0] wb_addr_seen = '0;
    logic [63:0] wb_data_seen = '0;

    function automatic logic [63:0] mem_rd(input logic [51:0] a);
        if (mem.exists(a)) return mem[a];
        return 64'd0;
    endfunction

    function automatic logic [51:0] ent_addr(input logic [39:0] tbl, input logic [35:0] vpn,
                                             input int lvl);
        logic [8:0] ix;
        ix = vpn[(3-lvl)*9 +: 9];
        return {tbl, ix, 3'b000};
    endfunction

    initial begin
        logic        lv = 1'b0;
        logic        lr = 1'b0;
        logic        lwe = 1'b0;
        logic [51:0] la = '0;
        logic [63:0] lwd = '0;
        logic        pend = 1'b0;
        int          pend_cnt = 0;
        logic [63:0] pend_data = '0;
        forever begin
            @(negedge clk);
            if (rst_n && lv && lr) begin
                if (lwe) begin
                    wr_cnt++;
                    wb_addr_seen = la;
                    wb_data_seen = lwd;
                    mem[la] = lwd;
                end else begin
                    if (rd_cnt < 4) rd_addr_log[rd_cnt] = la;
                    rd_cnt++;
                    pend = 1'b1;
                    pend_cnt = int'($urandom % 3);
                    pend_data = mem_rd(la);
                end
            end
            mem_rsp_valid_i = 1'b0;
            if (pend) begin
                if (pend_cnt == 0) begin
                    mem_rsp_valid_i = 1'b1;
                    mem_rsp_data_i  = pend_data;
                    pend = 1'b0;
                end else begin
                    pend_cnt--;
                end
            end
            mem_req_ready_i = ($urandom % 2) == 0;
            lv  = mem_req_valid_o;
            lr  = mem_req_ready_i;
            la  = mem_req_addr_o;
            lwe = mem_req_we_o;
            lwd = mem_req_wdata_o;
        end
    end

    // ---------------- reference model ----------------
    logic        x_fault;
    logic [1:0]  x_cause;
    logic [39:0] x_ppn;
    logic [11:0] x_flags;
    int          x_reads;
    logic [51:0] x_addr [4];
    logic [51:0] x_wb_addr;
    logic [63:0] x_wb_data;

    task automatic predict(input logic [35:0] vpn, input logic wr, input logic usr);
        logic [39:0] tbl;
        logic        pw;
        logic        pu;
        logic [63:0] e;
        logic [51:0] a;
        tbl = root_ppn_i;
        pw = 1'b1;
        pu = 1'b1;
        x_fault = 1'b0;
        x_cause = 2'd0;
        x_ppn = '0;
        x_flags = '0;
        x_reads = 0;
        x_wb_addr = '0;
        x_wb_data = '0;
        for (int l = 0; l < 4; l++) begin
            a = ent_addr(tbl, vpn, l);
            x_addr[l] = a;
            e = mem_rd(a);
            x_reads++;
            if (!e[0]) begin x_fault = 1'b1; x_cause = 2'd1; break; end
            if (usr && !e[2]) begin x_fault = 1'b1; x_cause = 2'd2; break; end
            if (wr && !e[1]) begin x_fault = 1'b1; x_cause = 2'd3; break; end
            pw &= e[1];
            pu &= e[2];
            if (l == 3) begin
                x_wb_addr = a;
                x_wb_data = e | 64'h20 | (wr ? 64'h40 : 64'h0);
                x_ppn = e[51:12];
                x_flags = x_wb_data[11:0];
                x_flags[1] = pw;
                x_flags[2] = pu;
            end else begin
                tbl = e[51:12];
            end
        end
    endtask

    // ---------------- one walk ----------------
    task automatic walk(input logic [35:0] vpn, input logic wr, input logic usr,
                        input string tag);
        logic        seen;
        logic        a_fault;
        logic [1:0]  a_cause;
        logic [39:0] a_ppn;
        logic [11:0] a_flags;
        predict(vpn, wr, usr);
        @(negedge clk);
        while (!req_ready_o) @(negedge clk);
        rd_cnt = 0;
        wr_cnt = 0;
        req_vpn_i = vpn;
        req_write_i = wr;
        req_user_i = usr;
        req_valid_i = 1'b1;
        @(negedge clk);
        req_valid_i = 1'b0;
        req_vpn_i = ~vpn;
        req_write_i = ~wr;
        req_user_i = ~usr;
        chk(req_ready_o == 1'b0, "R2", {tag, " busy after accept"}, 64'(req_ready_o), 64'd0);
        seen = 1'b0;
        for (int t = 0; t < 400; t++) begin
            if (done_valid_o) begin seen = 1'b1; break; end
            @(negedge clk);
        end
        chk(seen, "R11", {tag, " completion seen"}, 64'(seen), 64'd1);
        a_fault = done_fault_o;
        a_cause = done_cause_o;
        a_ppn = done_ppn_o;
        a_flags = done_flags_o;
        @(negedge clk);
        if (!seen) return;
        chk(done_valid_o == 1'b0 && req_ready_o == 1'b1, "R11", {tag, " single pulse"},
            64'({done_valid_o, req_ready_o}), 64'b01);
        chk(a_fault == x_fault, x_cause == 2'd0 ? "R9" : "R5", {tag, " fault"},
            64'(a_fault), 64'(x_fault));
        chk(a_cause == x_cause, x_cause == 2'd2 ? "R6" : (x_cause == 2'd3 ? "R7" : "R5"),
            {tag, " cause"}, 64'(a_cause), 64'(x_cause));
        chk(rd_cnt == x_reads, "R5", {tag, " read count"}, 64'(rd_cnt), 64'(x_reads));
        for (int l = 0; l < 4; l++) begin
            if (l < x_reads && l < rd_cnt)
                chk(rd_addr_log[l] == x_addr[l], l == 0 ? "R3" : "R4",
                    {tag, " entry address"}, 64'(rd_addr_log[l]), 64'(x_addr[l]));
        end
        chk(a_ppn == x_ppn, "R9", {tag, " ppn"}, 64'(a_ppn), 64'(x_ppn));
        chk(a_flags == x_flags, "R9", {tag, " flags"}, 64'(a_flags), 64'(x_flags));
        chk(wr_cnt == (x_fault ? 0 : 1), "R8", {tag, " write-back count"},
            64'(wr_cnt), 64'(x_fault ? 0 : 1));
        if (!x_fault && wr_cnt == 1) begin
            chk(wb_addr_seen == x_wb_addr, "R8", {tag, " write-back address"},
                64'(wb_addr_seen), 64'(x_wb_addr));
            chk(wb_data_seen == x_wb_data, "R8", {tag, " write-back data"},
                wb_data_seen, x_wb_data);
        end
    endtask

    // random tree population along one path
    task automatic grow(input logic [35:0] vpn);
        logic [39:0] tbl;
        logic [51:0] a;
        logic [63:0] e;
        tbl = root_ppn_i;
        for (int l = 0; l < 4; l++) begin
            a = ent_addr(tbl, vpn, l);
            if (!mem.exists(a) || ($urandom % 4) == 0) begin
                e = {$urandom, $urandom};
                e[0] = ($urandom % 12) != 0;
                e[1] = ($urandom % 6) != 0;
                e[2] = ($urandom % 6) != 0;
                e[5] = ($urandom % 2) == 0;
                e[6] = ($urandom % 3) == 0;
                mem[a] = e;
            end
            e = mem[a];
            if (!e[0]) break;
            tbl = e[51:12];
        end
    endtask

    function automatic logic [63:0] mk(input logic [39:0] nxt, input logic [11:0] f);
        return {12'h000, nxt, f};
    endfunction

    task automatic put_path(input logic [35:0] vpn, input logic [63:0] e0, input logic [63:0] e1,
                            input logic [63:0] e2, input logic [63:0] e3);
        mem[ent_addr(root_ppn_i, vpn, 0)] = e0;
        mem[ent_addr(e0[51:12], vpn, 1)] = e1;
        mem[ent_addr(e1[51:12], vpn, 2)] = e2;
        mem[ent_addr(e2[51:12], vpn, 3)] = e3;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [35:0] v;
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(req_ready_o == 1'b1, "R1", "ready after reset", 64'(req_ready_o), 64'd1);
        chk(mem_req_valid_o == 1'b0, "R1", "no memory request after reset",
            64'(mem_req_valid_o), 64'd0);
        chk(done_valid_o == 1'b0, "R1", "no completion after reset", 64'(done_valid_o), 64'd0);

        // R5: top-level entry invalid, other bits set
        v = 36'h1_2345_6789;
        mem[ent_addr(root_ppn_i, v, 0)] = 64'hFFFF_FFFF_FFFF_FFFE;
        walk(v, 1'b0, 1'b0, "R5 root invalid");

        // R8 R9 R3 R4: full write walk, upper bits of leaf preserved
        v = 36'hA_BCDE_F012;
        put_path(v, mk(40'h00_0000_1111, 12'h007), mk(40'h00_0000_2222, 12'h007),
                 mk(40'h00_0000_3333, 12'h007),
                 {12'hABC, 40'hDE_ADBE_EF01, 12'h807});
        walk(v, 1'b1, 1'b1, "R8 write walk");

        // R6: user request, level 2 kernel-only
        v = 36'h3_3333_0000;
        put_path(v, mk(40'h00_0000_4444, 12'h007), mk(40'h00_0000_5555, 12'h007),
                 mk(40'h00_0000_6666, 12'h003), mk(40'h00_0000_7777, 12'h007));
        walk(v, 1'b0, 1'b1, "R6 user denied");

        // R7: leaf denies both write and user, user store -> cause 2; kernel store -> cause 3
        v = 36'h4_0404_0404;
        put_path(v, mk(40'h00_0000_8888, 12'h007), mk(40'h00_0000_9999, 12'h007),
                 mk(40'h00_0000_AAAA, 12'h007), mk(40'h00_0000_BBBB, 12'h001));
        walk(v, 1'b1, 1'b1, "R7 priority user");
        walk(v, 1'b1, 1'b0, "R7 write denied");

        // R9: kernel read, level 1 read-only -> merged write flag cleared
        v = 36'h5_5555_5555;
        put_path(v, mk(40'h00_0000_CCCC, 12'h007), mk(40'h00_0000_DDDD, 12'h005),
                 mk(40'h00_0000_EEEE, 12'h007), mk(40'h00_0000_F0F0, 12'h067));
        walk(v, 1'b0, 1'b0, "R9 merged flags");

        // R5: leaf invalid
        v = 36'h6_0000_0001;
        put_path(v, mk(40'h00_0001_0001, 12'h007), mk(40'h00_0001_0002, 12'h007),
                 mk(40'h00_0001_0003, 12'h007), mk(40'h00_0001_0004, 12'h006));
        walk(v, 1'b0, 1'b0, "R5 leaf invalid");

        // R10: random ready and latency throughout; random trees
        for (int i = 0; i < 300; i++) begin
            v = 36'({$urandom, $urandom});
            if ((i % 5) == 0) v[8:0] = 9'h0;
            grow(v);
            walk(v, 1'($urandom % 2), 1'($urandom % 2), "R10 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule